// File: doc/BRIEF.md
# Odd-Even Transposition Sorter

This block sorts a small set of unsigned values into ascending order. It keeps them in a row of registers and sorts them over a fixed number of clocked stages. Between each pair of neighbouring registers sits a compare-and-swap unit. On each stage only one group of neighbours is active. The first group is the pairs that start on an even position. The second group is the pairs that start on an odd position. The two groups take turns. With four entries the sort finishes after four stages.

A parent block loads all entries in one cycle with a load pulse on a flat input vector. It then pulses start and waits for the done flag. The sorted row is visible at the output at every stage. When done is high the output stays fixed until the next load.

Top module: `oet_sorter`

## Requirements
- R1: While `rst_ni` is low, every register, the stage state and `done_o` are cleared. `sorted_o` reads all zero and `done_o` reads 0.
- R2: A cycle with `load_i` high copies `vals_i` into all positions on that clock edge and clears `done_o` and the stage state. Position i sits at bits [i*DATA_W +: DATA_W] of both `vals_i` and `sorted_o`.
- R3: When the block is idle and not done, a cycle with `start_i` high arms the sort. The first stage is applied on the next clock edge and one stage follows on each edge after that. Stages 1 and 3 compare positions (0,1) and (2,3). Stages 2 and 4 compare positions (1,2). For example, 8,5,7,3 becomes 5,8,3,7, then 5,3,8,7, then 3,5,7,8, then 3,5,7,8.
- R4: An active compare-swap unit puts the smaller value in the lower position. It leaves equal values where they are. A stage only reorders values and never changes them.
- R5: `done_o` rises on the same edge that applies the fourth stage. At that point `sorted_o` is in ascending order with the smallest value in position 0.
- R6: Once `done_o` is high, it and `sorted_o` stay unchanged until the next load. A `start_i` pulse while done has no effect.
- R7: `load_i` takes priority over a sort in progress. It replaces the values, stops the sort, and leaves the block idle and not done.
- R8: A `start_i` pulse during a running sort neither restarts nor extends it. `done_o` still rises on the edge of the fourth stage counted from the original start.
- R9: When the block is idle and not loading, `sorted_o` holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load of all positions |
| vals_i | input | N_VALS*DATA_W | Values to load, position 0 in the low bits |
| start_i | input | 1 | Begins a sort when idle and not done |
| sorted_o | output | N_VALS*DATA_W | Current register row, position 0 in the low bits |
| done_o | output | 1 | High after the last stage, until the next load |

## Verification
The bench builds the block with its default parameters, four entries of four bits each. At that size every stage of every sort can be predicted in full and compared cycle by cycle. This covers the stated four-value example stage by stage, rows that are fully reversed, already sorted or hold repeated values, and a series of rows from a pseudo-random generator. The default size also makes the timing corner cases cheap to reach: a load arriving in the middle of a sort, a start arriving during a sort or after done, and idle cycles with no start.

// File: rtl/oet_pkg.sv
package oet_pkg;
  typedef enum logic {
    PH_OUTER  = 1'b0,  // pairs starting at even positions
    PH_MIDDLE = 1'b1   // pairs starting at odd positions
  } phase_e;
endpackage

// File: rtl/oet_cmp_swap.sv
module oet_cmp_swap #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] c_o,
  output logic [DATA_W-1:0] d_o
);
  logic swap;

  // strict compare: equal values pass through
  assign swap = a_i > b_i;
  assign c_o  = swap ? b_i : a_i;
  assign d_o  = swap ? a_i : b_i;
endmodule

// File: rtl/oet_stage_seq.sv
module oet_stage_seq
  import oet_pkg::*;
#(
  parameter int N_VALS = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  logic   start_i,
  output logic   run_o,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int CNT_W = (N_VALS > 2) ? $clog2(N_VALS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_VALS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (cnt_q == LAST_CNT) begin
        cnt_q  <= '0;
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i && !done_q) begin
      run_q <= 1'b1;
    end
  end

  assign run_o   = run_q;
  assign done_o  = done_q;
  assign phase_o = cnt_q[0] ? PH_MIDDLE : PH_OUTER;

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!done_q && !run_q)); // R2
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !load_i) |=> (done_q && !run_q)); // R6
  AST_RUN_NOT_EXTENDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !load_i && cnt_q == LAST_CNT) |=> (!run_q && done_q)); // R8
  AST_RUN_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_q && done_q)); // R5
endmodule

// File: rtl/oet_reg_row.sv
module oet_reg_row #(
  parameter int DATA_W = 4,
  parameter int N_VALS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [N_VALS-1:0][DATA_W-1:0]  load_vals_i,
  input  logic                           upd_i,
  input  logic [N_VALS-1:0][DATA_W-1:0]  upd_vals_i,
  output logic [N_VALS-1:0][DATA_W-1:0]  vals_o
);
  logic [N_VALS-1:0][DATA_W-1:0] vals_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vals_q <= '0;
    else if (load_i) vals_q <= load_vals_i;
    else if (upd_i)  vals_q <= upd_vals_i;
  end

  assign vals_o = vals_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !upd_i) |=> $stable(vals_q)); // R9
  AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (vals_q == $past(load_vals_i))); // R2
endmodule

// File: rtl/oet_sorter.sv
module oet_sorter
  import oet_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int N_VALS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [N_VALS*DATA_W-1:0] vals_i,
  input  logic                     start_i,
  output logic [N_VALS*DATA_W-1:0] sorted_o,
  output logic                     done_o
);
  localparam int N_PAIRS = N_VALS - 1;
  localparam int SUM_W   = DATA_W + $clog2(N_VALS) + 1;

  logic                          run;
  phase_e                        phase;
  logic [N_VALS-1:0][DATA_W-1:0] row_q;
  logic [N_VALS-1:0][DATA_W-1:0] row_in;
  logic [N_VALS-1:0][DATA_W-1:0] row_nxt;
  logic [N_PAIRS-1:0][DATA_W-1:0] lo;
  logic [N_PAIRS-1:0][DATA_W-1:0] hi;
  logic [N_PAIRS-1:0]            pair_en;

  oet_stage_seq #(.N_VALS(N_VALS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .start_i (start_i),
    .run_o   (run),
    .phase_o (phase),
    .done_o  (done_o)
  );

  assign row_in = vals_i;

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    oet_cmp_swap #(.DATA_W(DATA_W)) u_cs (
      .a_i (row_q[i]),
      .b_i (row_q[i+1]),
      .c_o (lo[i]),
      .d_o (hi[i])
    );
    if ((i % 2) == 0) begin : g_outer
      assign pair_en[i] = run && (phase == PH_OUTER);
    end else begin : g_middle
      assign pair_en[i] = run && (phase == PH_MIDDLE);
    end
  end

  // active pairs of one phase never share a position
  always_comb begin
    row_nxt = row_q;
    for (int i = 0; i < N_PAIRS; i++) begin
      if (pair_en[i]) begin
        row_nxt[i]   = lo[i];
        row_nxt[i+1] = hi[i];
      end
    end
  end

  oet_reg_row #(.DATA_W(DATA_W), .N_VALS(N_VALS)) u_row (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_vals_i (row_in),
    .upd_i       (run),
    .upd_vals_i  (row_nxt),
    .vals_o      (row_q)
  );

  assign sorted_o = row_q;

  function automatic logic is_ascending(input logic [N_VALS-1:0][DATA_W-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N_PAIRS; i++) if (r[i] > r[i+1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [SUM_W-1:0] row_sum(input logic [N_VALS-1:0][DATA_W-1:0] r);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int i = 0; i < N_VALS; i++) s = s + SUM_W'(r[i]);
    return s;
  endfunction

  AST_DONE_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> is_ascending(row_q)); // R5
  AST_STAGE_KEEPS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load_i) |=> (row_sum(row_q) == $past(row_sum(row_q)))); // R4
  AST_PAIRS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pair_en & {N_PAIRS{1'b1}}) || (phase == PH_OUTER) || (N_PAIRS < 3)); // R3
endmodule

// File: tb/sim_oet_sorter.sv
module sim_oet_sorter;
  localparam int TCK    = 10;
  localparam int DATA_W = 4;
  localparam int N_VALS = 4;
  localparam int VW     = N_VALS * DATA_W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [VW-1:0] vals_i = '0;
  logic          start_i = 1'b0;
  logic [VW-1:0] sorted_o;
  logic          done_o;

  oet_sorter #(.DATA_W(DATA_W), .N_VALS(N_VALS)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .vals_i(vals_i),
    .start_i(start_i), .sorted_o(sorted_o), .done_o(done_o)
  );

  always #(TCK/2) clk_i = ~clk_i;

  typedef struct {
    int            due;
    logic [VW-1:0] v;
    logic          d;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  // bench model of the requirements
  logic [DATA_W-1:0] m [N_VALS];
  logic m_run = 1'b0, m_done = 1'b0;
  int   m_cnt = 0;

  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  function automatic logic [VW-1:0] pack_m();
    logic [VW-1:0] r;
    for (int i = 0; i < N_VALS; i++) r[i*DATA_W +: DATA_W] = m[i];
    return r;
  endfunction

  task automatic step(input logic ld, input logic [VW-1:0] v, input logic st, input string tag);
    exp_t e;
    @(negedge clk_i);
    load_i  = ld;
    vals_i  = v;
    start_i = st;
    if (ld) begin
      for (int i = 0; i < N_VALS; i++) m[i] = v[i*DATA_W +: DATA_W];
      m_run = 1'b0; m_done = 1'b0; m_cnt = 0;
    end else if (m_run) begin
      // R3: odd stages (cnt even) use pairs from even positions
      for (int i = 0; i < N_VALS - 1; i++) begin
        if ((i % 2) == (m_cnt % 2) && m[i] > m[i+1]) begin
          logic [DATA_W-1:0] t;
          t = m[i]; m[i] = m[i+1]; m[i+1] = t;
        end
      end
      if (m_cnt == N_VALS - 1) begin
        m_run = 1'b0; m_done = 1'b1; m_cnt = 0;
      end else m_cnt++;
    end else if (st && !m_done) begin
      m_run = 1'b1;
    end
    e.due = cyc + 1; e.v = pack_m(); e.d = m_done; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, vals_i, 1'b0, tag);
  endtask

  task automatic sort_run(input logic [VW-1:0] v, input string tag);
    step(1'b1, v, 1'b0, "R2 load");
    step(1'b0, v, 1'b1, "R3 start");
    idle(3, tag);
    step(1'b0, v, 1'b0, "R5 final stage");
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (sorted_o !== e.v || done_o !== e.d) begin
        n_fail++;
        $display("FAIL %s: got vals=%h done=%b, expected vals=%h done=%b",
                 e.tag, sorted_o, done_o, e.v, e.d);
      end
    end
  end

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] lfsr;
    for (int i = 0; i < N_VALS; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    n_chk++;
    if (sorted_o !== '0 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got vals=%h done=%b, expected vals=0 done=0", sorted_o, done_o);
    end
    rst_ni = 1'b1;

    // R2, R9: load then idle without start
    step(1'b1, 16'h3758, 1'b0, "R2 load 8,5,7,3");
    idle(2, "R9 idle hold");
    // R3: stage-by-stage example
    step(1'b0, 16'h3758, 1'b1, "R3 start");
    step(1'b0, 16'h3758, 1'b0, "R3 stage1 5,8,3,7");
    step(1'b0, 16'h3758, 1'b0, "R3 stage2 5,3,8,7");
    step(1'b0, 16'h3758, 1'b0, "R3 stage3 3,5,7,8");
    step(1'b0, 16'h3758, 1'b0, "R5 stage4 done");
    // R6: done holds, start ignored
    step(1'b0, 16'h3758, 1'b1, "R6 start while done");
    idle(2, "R6 done hold");

    // R7: load in mid-sort
    step(1'b1, 16'h0F1E, 1'b0, "R2 load");
    step(1'b0, 16'h0F1E, 1'b1, "R3 start");
    step(1'b0, 16'h0F1E, 1'b0, "R3 stage1");
    step(1'b1, 16'h9A4C, 1'b0, "R7 load mid-sort");
    idle(2, "R7 idle after abort");
    // R8: start during run does not restart
    step(1'b0, 16'h9A4C, 1'b1, "R3 start");
    step(1'b0, 16'h9A4C, 1'b1, "R8 start while running");
    step(1'b0, 16'h9A4C, 1'b1, "R8 start while running");
    step(1'b0, 16'h9A4C, 1'b0, "R8 stage3");
    step(1'b0, 16'h9A4C, 1'b0, "R8 done on time");

    // R4: corner rows
    sort_run(16'h0123, "R4 reversed");
    sort_run(16'h3210, "R4 already sorted");
    sort_run(16'h2255, "R4 repeated values");
    sort_run(16'h7777, "R4 all equal");
    sort_run(16'h0F0F, "R4 extremes");
    sort_run(16'h0000, "R4 zeros");

    // R5: pseudo-random rows
    lfsr = 16'hACE1;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sort_run(lfsr, "R5 random row");
    end

    repeat (3) @(negedge clk_i);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule